// File: doc/BRIEF.md
# Multi-Cycle Memory Read Sequencer

This block is a processor-side bus master that performs one read from a slow memory using a fixed handshake. A read request with an address on the processor side starts a transaction. The sequencer puts the address on the memory address bus. It then pulls an active-low read strobe low for two cycles, so that memory has one full cycle to place its word on the data bus. It then releases the strobe, captures the word and returns it together with a one-cycle valid pulse.

A transaction always lasts four cycles. The states are IDLE, SETUP (the address is driven and the strobe is still high), STROBE (the strobe goes low), WAIT (the strobe stays low while memory answers) and DONE (the strobe is released and the data is valid). The transitions are as follows. IDLE→SETUP happens on a sampled request. SETUP→STROBE, STROBE→WAIT, WAIT→DONE and DONE→IDLE happen unconditionally. Any state goes to IDLE on a synchronous reset. The data word is taken from the bus on the clock edge that leaves WAIT.

Top module: `mem_rd_seq`

## Requirements
- R1: After a synchronous active-high reset, the block is idle: `mem_rd_n_o`=1, `busy_o`=0, `rvalid_o`=0.
- R2: A request sampled while idle starts a transaction. In the next cycle (SETUP), `busy_o`=1, `mem_addr_o` equals the requested address and `mem_rd_n_o` is still 1.
- R3: The strobe `mem_rd_n_o` is low for exactly two consecutive cycles, which are the second and third cycles of the transaction.
- R4: In the fourth cycle, `mem_rd_n_o` returns to 1 and `rvalid_o` is high for that one cycle only.
- R5: `rdata_o` equals the value present on `mem_data_i` in the last strobe-low cycle (the wait cycle). It holds that value until the next transaction captures a new one.
- R6: `mem_addr_o` stays stable through all four cycles of a transaction.
- R7: A request that arrives while `busy_o`=1 is ignored. The address does not change, and no new transaction starts from the SETUP, STROBE, WAIT or DONE states.
- R8: `busy_o` is high from the cycle after acceptance through the valid cycle and is low in the cycle that follows. A request held continuously therefore starts a new transaction every five cycles.
- R9: A reset asserted during a transaction returns the block to idle at the next clock edge, with the strobe high and `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Read request, sampled while idle |
| req_addr_i | input | ADDR_W | Address of the requested read |
| mem_addr_o | output | ADDR_W | Address bus toward memory |
| mem_rd_n_o | output | 1 | Read strobe, active low |
| mem_data_i | input | DATA_W | Data bus from memory |
| rdata_o | output | DATA_W | Captured read word |
| rvalid_o | output | 1 | One-cycle pulse when `rdata_o` is new |
| busy_o | output | 1 | Transaction in progress |

## Verification
The assertions assume that the first clock edge comes while reset is high. They also assume that memory's data is meaningful only after the strobe has been low for a full cycle. The strobe-length and valid checks hold that the strobe release is always the end of a transaction, except right after a reset. The bench memory model drives data only in the second strobe-low cycle and drives zero at all other times. Its requests are applied and removed at the falling clock edge, so a capture taken too early or too late shows up as a wrong word.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_SETUP  = 3'd1,
        S_STROBE = 3'd2,
        S_WAIT   = 3'd3,
        S_DONE   = 3'd4
    } mrs_state_e;
endpackage

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
    import mrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic accept_o,
    output logic cap_en_o,
    output logic rd_n_o,
    output logic busy_o,
    output logic valid_o
);
    mrs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_i) state_d = S_SETUP;
            S_SETUP:  state_d = S_STROBE;
            S_STROBE: state_d = S_WAIT;
            S_WAIT:   state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        accept_o = 1'b0;
        cap_en_o = 1'b0;
        rd_n_o   = 1'b1;
        busy_o   = 1'b1;
        valid_o  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy_o   = 1'b0;
                accept_o = req_i;
            end
            S_SETUP:  ;
            S_STROBE: rd_n_o = 1'b0;
            S_WAIT: begin
                rd_n_o   = 1'b0;
                cap_en_o = 1'b1;
            end
            S_DONE:   valid_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE) |=> (state_q != S_SETUP)); // R7
    AST_STROBE_FOLLOWS_SETUP: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_SETUP) |=> !rd_n_o); // R3
endmodule

// File: rtl/mrs_addr_hold.sv
module mrs_addr_hold #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_ff @(posedge clk) begin
        if (rst)         addr_o <= '0;
        else if (load_i) addr_o <= addr_i;
    end
endmodule

// File: rtl/mrs_capture.sv
module mrs_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] word_o
);
    always_ff @(posedge clk) begin
        if (rst)       word_o <= '0;
        else if (en_i) word_o <= bus_i;
    end
endmodule

// File: rtl/mem_rd_seq.sv
module mem_rd_seq #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_n_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              busy_o
);
    logic accept;
    logic cap_en;

    mrs_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req_i),
        .accept_o (accept),
        .cap_en_o (cap_en),
        .rd_n_o   (mem_rd_n_o),
        .busy_o   (busy_o),
        .valid_o  (rvalid_o)
    );

    mrs_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .addr_i (req_addr_i),
        .addr_o (mem_addr_o)
    );

    mrs_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .en_i   (cap_en),
        .bus_i  (mem_data_i),
        .word_o (rdata_o)
    );

    AST_STROBE_TWO_LOW: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_n_o && $past(!mem_rd_n_o)) |=> mem_rd_n_o); // R3
    AST_RELEASE_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_rd_n_o) && !$past(rst)) |-> rvalid_o); // R4
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |=> !rvalid_o); // R4
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o)); // R6
    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
        rvalid_o |=> !busy_o); // R8
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (!rvalid_o && !$past(rst)) |-> $stable(rdata_o)); // R5
endmodule

// File: tb/tb_mem_rd_seq.sv
module tb_mem_rd_seq;
    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [AW-1:0] mem_addr_o;
    logic          mem_rd_n_o;
    logic [DW-1:0] mem_data_i;
    logic [DW-1:0] rdata_o;
    logic          rvalid_o;
    logic          busy_o;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;
    logic was_low = 1'b0;

    always #2 clk = ~clk;

    mem_rd_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .req_i(req_i), .req_addr_i(req_addr_i),
        .mem_addr_o(mem_addr_o), .mem_rd_n_o(mem_rd_n_o), .mem_data_i(mem_data_i),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o), .busy_o(busy_o)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hA5C3 ^ {12'h000, a[19:16]};
    endfunction

    // memory answers only after the strobe has been low for a full cycle
    always_ff @(posedge clk) was_low <= rst ? 1'b0 : !mem_rd_n_o;
    assign mem_data_i = (!mem_rd_n_o && was_low) ? mem_word(mem_addr_o) : '0;

    // address, expected word
    localparam logic [35:0] VEC [6] = '{
        {20'h00000, 16'hA5C3}, {20'hFFFFF, 16'h5A33}, {20'h08F10, 16'h2AD3},
        {20'h12345, 16'h8687}, {20'hA5C3B, 16'hF9F2}, {20'h02920, 16'h8CE3}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // runs one read; checks every cycle of it
    task automatic read_txn(input logic [AW-1:0] a, input logic [DW-1:0] exp, input bit poke);
        req_i = 1'b1; req_addr_i = a;
        step();
        req_i = poke; req_addr_i = ~a;
        chk(busy_o == 1 && mem_rd_n_o == 1, "R2 setup busy/strobe", {busy_o, mem_rd_n_o}, 2'b11);
        chk(mem_addr_o == a, "R2 address", mem_addr_o, a);
        step();
        chk(mem_rd_n_o == 0 && busy_o == 1, "R3 strobe low c2", mem_rd_n_o, 0);
        chk(mem_addr_o == a, "R6 address c2", mem_addr_o, a);
        step();
        chk(mem_rd_n_o == 0 && rvalid_o == 0, "R3 strobe low c3", mem_rd_n_o, 0);
        chk(mem_addr_o == a, "R6 address c3", mem_addr_o, a);
        step();
        chk(mem_rd_n_o == 1 && rvalid_o == 1 && busy_o == 1, "R4 release+valid c4",
            {mem_rd_n_o, rvalid_o, busy_o}, 3'b111);
        chk(rdata_o == exp, "R5 captured word", rdata_o, exp);
        chk(mem_addr_o == a, "R6 address c4", mem_addr_o, a);
        req_i = 1'b0;
        step();
        chk(busy_o == 0 && rvalid_o == 0, "R8 idle after valid", {busy_o, rvalid_o}, 2'b00);
        chk(rdata_o == exp, "R5 word held", rdata_o, exp);
    endtask

    initial begin
        @(negedge clk);
        step();
        chk(mem_rd_n_o == 1 && busy_o == 0 && rvalid_o == 0, "R1 reset state",
            {mem_rd_n_o, busy_o, rvalid_o}, 3'b100);
        rst = 1'b0;
        step();
        chk(mem_rd_n_o == 1 && busy_o == 0, "R1 idle after reset", {mem_rd_n_o, busy_o}, 2'b10);

        for (int i = 0; i < 6; i++)
            read_txn(VEC[i][35:16], VEC[i][15:0], 1'b0);

        // R7: request held high with another address during the transaction
        read_txn(20'h3C0F1, mem_word(20'h3C0F1), 1'b1);
        step();
        chk(busy_o == 0 && rdata_o == mem_word(20'h3C0F1), "R7 no restart, word kept",
            {busy_o, rdata_o}, {1'b0, mem_word(20'h3C0F1)});

        // R8: continuous request -> five-cycle period
        req_i = 1'b1; req_addr_i = 20'h00ABC;
        step();
        repeat (4) step();
        chk(busy_o == 0, "R8 gap cycle with held request", busy_o, 0);
        step();
        chk(busy_o == 1 && mem_rd_n_o == 1, "R8 next accept after gap", {busy_o, mem_rd_n_o}, 2'b11);
        req_i = 1'b0;
        repeat (4) step();

        // R9: reset in the middle of the strobe
        req_i = 1'b1; req_addr_i = 20'h55555;
        step();
        req_i = 1'b0;
        step();
        chk(mem_rd_n_o == 0, "R9 strobe low before reset", mem_rd_n_o, 0);
        rst = 1'b1;
        step();
        chk(mem_rd_n_o == 1 && busy_o == 0 && rvalid_o == 0, "R9 idle after mid reset",
            {mem_rd_n_o, busy_o, rvalid_o}, 3'b100);
        rst = 1'b0;
        step();
        read_txn(20'h0BEEF, mem_word(20'h0BEEF), 1'b0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule